// File: doc/BRIEF.md
# Secure Boot Measurement Sequencer

This block sits inside a small security processor and decides whether the main CPU may run past its loader. Right after reset it takes a snapshot of its configuration inputs and of a unary fuse counter. From the fuse counter it derives a safe-mode flag, which is high when the number of blown fuses is odd. It then waits for the main CPU to report that its images are in memory. At that point it pulls the CPU enable low and locks CPU writes to the protected code area.

With the CPU held, it reads the protected region word by word through a read-only memory master. Each returned word is passed in address order into an external hash engine. When the engine reports its digest, the block compares all digest bits against the stored reference in one cycle. A match releases the CPU for good. A mismatch parks the block in a terminal failure state, with the CPU held and a failure flag raised.

Both data paths use valid/ready. A request is held, with its address unchanged, until `mrd_ready` is seen high. A response word moves only when the hash engine accepts it, because `mrsp_ready` is the hash engine's `hash_ready` passed straight through during streaming. Back-pressure on either side therefore stalls the walk without losing or reordering words. Responses must come back in request order. The control and status pins are plain levels.

Top module: `boot_measure_seq`

## Requirements
- R1: `safe_mode` equals the XOR of all `fuse_ctr` bits sampled in the first cycle after reset. It does not change again until the next reset.
- R2: Until `cpu_ready` is accepted, `cpu_enable` is high, `wr_lock` is low, and neither `mrd_valid` nor `hash_start` is asserted.
- R3: In the cycle after `cpu_ready` is accepted, `cpu_enable` is low. It stays low for as long as any memory request or hash word is in flight.
- R4: `wr_lock` goes high in the cycle after `cpu_ready` is accepted. It is high whenever `mrd_valid` is high, and it drops only on a successful match.
- R5: Exactly `cfg_len` read requests are issued, at addresses base, base+1, … base+len-1 modulo 2^ADDR_W, in that order. A request that is not accepted keeps `mrd_valid` high and `mrd_addr` stable.
- R6: Every returned word reaches `hash_data` unchanged and in request order. `hash_last` is high on the final word only.
- R7: If the digest returned with `hash_done` equals the reference on every bit, `cpu_enable` goes high, `wr_lock` and `boot_fail` go low, and this state holds until reset.
- R8: If any digest bit differs, `boot_fail` goes high, `cpu_enable` stays low and `wr_lock` stays high, until reset.
- R9: A region length of zero sends the block to the failure state as soon as `cpu_ready` is accepted, with no memory request and no `hash_start`.
- R10: Changes on `cfg_base`, `cfg_len`, `cfg_ref` or `fuse_ctr` after the first cycle following reset have no effect on the addresses, the word count, the verdict or `safe_mode`.
- R11: `hash_start` is a single-cycle pulse, issued once per boot in the cycle after `cpu_ready` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Word address of the protected region |
| cfg_len | input | LEN_W | Region length in words |
| cfg_ref | input | DIG_W | Reference digest |
| fuse_ctr | input | FUSE_W | Unary safe-mode fuse counter |
| safe_mode | output | 1 | Odd fuse count flag |
| cpu_ready | input | 1 | Main CPU reports images loaded |
| cpu_enable | output | 1 | Main CPU may run |
| wr_lock | output | 1 | Block CPU writes to protected area |
| boot_fail | output | 1 | Measurement mismatch, terminal |
| mrd_valid | output | 1 | Read request valid |
| mrd_ready | input | 1 | Read request accepted |
| mrd_addr | output | ADDR_W | Read request word address |
| mrsp_valid | input | 1 | Read data valid |
| mrsp_ready | output | 1 | Read data accepted |
| mrsp_data | input | DATA_W | Read data |
| hash_start | output | 1 | Begin a new digest |
| hash_valid | output | 1 | Hash input word valid |
| hash_ready | input | 1 | Hash engine accepts word |
| hash_data | output | DATA_W | Hash input word |
| hash_last | output | 1 | Final word of the region |
| hash_done | input | 1 | Digest available |
| hash_digest | input | DIG_W | Computed digest |

## Verification
The bench sweeps region lengths from one to eight words under several stall patterns on the request, response and hash sides. It also walks a region that wraps past the top of the address space. A design that drops or repeats a word under back-pressure, or that lets the address move while a request waits, would show a wrong word count, a bad address or a wrong word order. Mismatches are forced on the lowest and the highest digest bit, because a comparator that ignores either end would release a tampered CPU. The bench also tries a zero-length region, which a careless design would either hang on or release. Configuration and fuse inputs are changed right after the snapshot, to catch a design that keeps tracking live inputs. All fuse values are swept to check the parity rule.

// File: rtl/bms_pkg.sv
package bms_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_WAIT,
    ST_START,
    ST_STREAM,
    ST_DIGEST,
    ST_PASS,
    ST_FAIL
  } seq_state_t;
endpackage

// File: rtl/bms_fuse_latch.sv
module bms_fuse_latch #(
  parameter int FUSE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [FUSE_W-1:0] fuse_in,
  output logic              safe_mode
);
  logic captured_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      safe_mode  <= 1'b0;
      captured_q <= 1'b0;
    end else if (capture && !captured_q) begin
      safe_mode  <= ^fuse_in;
      captured_q <= 1'b1;
    end
  end

  AST_SAFE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    captured_q |=> $stable(safe_mode)); // R1
endmodule

// File: rtl/bms_fetch.sv
module bms_fetch #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [ADDR_W-1:0] mrd_addr,
  input  logic              rsp_fire,
  output logic              last_word,
  output logic              all_done
);
  logic             active_q;
  logic [LEN_W-1:0] req_cnt;
  logic [LEN_W-1:0] rsp_cnt;

  assign mrd_valid = active_q && (req_cnt != len);
  assign mrd_addr  = base + ADDR_W'(req_cnt);
  assign last_word = active_q && (rsp_cnt == len - LEN_W'(1));
  assign all_done  = rsp_fire && last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      req_cnt  <= '0;
      rsp_cnt  <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      req_cnt  <= '0;
      rsp_cnt  <= '0;
    end else begin
      if (mrd_valid && mrd_ready) req_cnt <= req_cnt + LEN_W'(1);
      if (rsp_fire && active_q)   rsp_cnt <= rsp_cnt + LEN_W'(1);
      if (all_done)               active_q <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr))); // R5
  AST_RSP_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (rsp_cnt <= req_cnt)); // R6
endmodule

// File: rtl/bms_digest_eq.sv
module bms_digest_eq #(
  parameter int DIG_W = 64
) (
  input  logic [DIG_W-1:0] computed,
  input  logic [DIG_W-1:0] expected,
  output logic             equal
);
  logic [DIG_W-1:0] diff;
  assign diff  = computed ^ expected;
  assign equal = (diff == '0);
endmodule

// File: rtl/boot_measure_seq.sv
module boot_measure_seq
  import bms_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DIG_W  = 64,
  parameter int FUSE_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DIG_W-1:0]  cfg_ref,
  input  logic [FUSE_W-1:0] fuse_ctr,
  output logic              safe_mode,
  input  logic              cpu_ready,
  output logic              cpu_enable,
  output logic              wr_lock,
  output logic              boot_fail,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [ADDR_W-1:0] mrd_addr,
  input  logic              mrsp_valid,
  output logic              mrsp_ready,
  input  logic [DATA_W-1:0] mrsp_data,
  output logic              hash_start,
  output logic              hash_valid,
  input  logic              hash_ready,
  output logic [DATA_W-1:0] hash_data,
  output logic              hash_last,
  input  logic              hash_done,
  input  logic [DIG_W-1:0]  hash_digest
);
  seq_state_t        state, state_nx;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [DIG_W-1:0]  ref_q;
  logic              streaming;
  logic              rsp_fire;
  logic              last_word;
  logic              all_done;
  logic              dig_match;

  bms_fuse_latch #(.FUSE_W(FUSE_W)) u_fuse (
    .clk(clk), .rst_n(rst_n), .capture(state == ST_INIT),
    .fuse_in(fuse_ctr), .safe_mode(safe_mode)
  );

  bms_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(state == ST_START),
    .base(base_q), .len(len_q),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .rsp_fire(rsp_fire), .last_word(last_word), .all_done(all_done)
  );

  bms_digest_eq #(.DIG_W(DIG_W)) u_cmp (
    .computed(hash_digest), .expected(ref_q), .equal(dig_match)
  );

  assign streaming  = (state == ST_STREAM);
  assign mrsp_ready = streaming && hash_ready;
  assign hash_valid = streaming && mrsp_valid;
  assign hash_data  = mrsp_data;
  assign hash_last  = streaming && last_word;
  assign rsp_fire   = mrsp_valid && mrsp_ready;
  assign hash_start = (state == ST_START);
  assign cpu_enable = (state == ST_INIT) || (state == ST_WAIT) || (state == ST_PASS);
  assign wr_lock    = (state == ST_START) || (state == ST_STREAM) ||
                      (state == ST_DIGEST) || (state == ST_FAIL);
  assign boot_fail  = (state == ST_FAIL);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_INIT:   state_nx = ST_WAIT;
      ST_WAIT:   if (cpu_ready) state_nx = (len_q == '0) ? ST_FAIL : ST_START;
      ST_START:  state_nx = ST_STREAM;
      ST_STREAM: if (all_done) state_nx = ST_DIGEST;
      ST_DIGEST: if (hash_done) state_nx = dig_match ? ST_PASS : ST_FAIL;
      ST_PASS:   state_nx = ST_PASS;
      ST_FAIL:   state_nx = ST_FAIL;
      default:   state_nx = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_INIT;
      base_q <= '0;
      len_q  <= '0;
      ref_q  <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_INIT) begin
        base_q <= cfg_base;
        len_q  <= cfg_len;
        ref_q  <= cfg_ref;
      end
    end
  end

  AST_HELD_WHILE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid || hash_valid) |-> !cpu_enable); // R3
  AST_LOCK_WHILE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid |-> wr_lock); // R4
  AST_PASS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_enable && !wr_lock && $past(wr_lock)) |=> (cpu_enable && !wr_lock && !boot_fail)); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_fail |=> (boot_fail && !cpu_enable && wr_lock)); // R8
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |=> !hash_start); // R11
endmodule

// File: tb/boot_measure_seq_test.sv
module boot_measure_seq_test;
  localparam int ADDR_W = 16, DATA_W = 32, DIG_W = 64, FUSE_W = 8, LEN_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [LEN_W-1:0]  cfg_len = '0;
  logic [DIG_W-1:0]  cfg_ref = '0;
  logic [FUSE_W-1:0] fuse_ctr = '0;
  logic safe_mode, cpu_ready = 1'b0, cpu_enable, wr_lock, boot_fail;
  logic mrd_valid, mrd_ready = 1'b0, mrsp_valid = 1'b0, mrsp_ready;
  logic [ADDR_W-1:0] mrd_addr;
  logic [DATA_W-1:0] mrsp_data = '0, hash_data;
  logic hash_start, hash_valid, hash_ready = 1'b0, hash_last, hash_done = 1'b0;
  logic [DIG_W-1:0] hash_digest = '0;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  boot_measure_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIG_W(DIG_W),
                     .FUSE_W(FUSE_W), .LEN_W(LEN_W)) uut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] memval(input logic [ADDR_W-1:0] a);
    return {a, a ^ 16'hC3A5};
  endfunction

  function automatic logic [DIG_W-1:0] mix(input logic [DIG_W-1:0] acc, input logic [DATA_W-1:0] w);
    return {acc[58:0], acc[63:59]} ^ {w, ~w} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic bit pat(input int mode, input int cyc, input int salt);
    if (mode == 0) return 1'b1;
    return ((cyc * (salt + mode) + salt) % (mode + 2)) != 0;
  endfunction

  logic [ADDR_W-1:0] q [0:511];

  task automatic run_case(input logic [ADDR_W-1:0] base, input int len, input int flip,
                          input int mode, input logic [FUSE_W-1:0] fuse,
                          input bit tamper, input int rdy_delay);
    logic [DIG_W-1:0] expd, acc;
    int qw, qr, reqs, words, starts, cnt, done_cd, timeout;
    bit quiet, lock_ok, hold_ok, exp_pass, done_sent;
    expd = '0;
    for (int i = 0; i < len; i++) expd = mix(expd, memval(base + ADDR_W'(i)));
    exp_pass = (flip < 0) && (len > 0);
    cfg_base = base; cfg_len = LEN_W'(len);
    cfg_ref = (flip >= 0) ? (expd ^ (64'd1 << flip)) : expd;
    fuse_ctr = fuse;
    rst_n = 1'b0; cpu_ready = 1'b0; mrd_ready = 1'b0; mrsp_valid = 1'b0;
    hash_ready = 1'b0; hash_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    if (tamper) begin
      cfg_base = base + 16'h0100; cfg_len = 8'd2; cfg_ref = '0; fuse_ctr = ~fuse ^ 8'h01;
    end
    chk(safe_mode == ^fuse, "R1 safe_mode parity", safe_mode, ^fuse);
    chk(cpu_enable && !wr_lock && !boot_fail, "R2 reset state", {cpu_enable, wr_lock, boot_fail}, 3'b100);
    quiet = 1'b1;
    for (int i = 0; i < rdy_delay; i++) begin
      @(negedge clk);
      if (mrd_valid || hash_start || !cpu_enable || wr_lock) quiet = 1'b0;
    end
    chk(quiet, "R2 idle before ready", quiet, 1);
    cpu_ready = 1'b1;
    @(negedge clk);
    chk(!cpu_enable, "R3 enable dropped", cpu_enable, 0);
    chk(wr_lock, "R4 lock raised", wr_lock, 1);
    if (len == 0) begin
      chk(boot_fail && !hash_start && !mrd_valid, "R9 zero length fails",
          {boot_fail, hash_start, mrd_valid}, 3'b100);
      starts = 0;
    end else begin
      chk(hash_start, "R11 start pulse", hash_start, 1);
      starts = 1;
    end
    qw = 0; qr = 0; reqs = 0; words = 0; cnt = 0; done_cd = -1; acc = '0;
    lock_ok = 1'b1; hold_ok = 1'b1; done_sent = 1'b0; timeout = 0;
    while (!cpu_enable && !boot_fail && timeout < 3000) begin
      @(negedge clk);
      cnt++; timeout++;
      if (hash_start) starts++;
      mrd_ready  = pat(mode, cnt, 3);
      hash_ready = pat(mode, cnt, 5);
      mrsp_valid = (qw != qr) && pat(mode, cnt, 7);
      mrsp_data  = memval(q[qr % 512]);
      hash_done  = (done_cd == 0);
      hash_digest = acc;
      if (done_cd >= 0) done_cd--;
      if (hash_done) done_sent = 1'b1;
      #1;
      if (mrd_valid && (!wr_lock || cpu_enable)) lock_ok = 1'b0;
      if (hash_valid && cpu_enable) hold_ok = 1'b0;
      if (mrd_valid && mrd_ready) begin
        chk(mrd_addr == base + ADDR_W'(reqs), "R5 address order", mrd_addr, base + ADDR_W'(reqs));
        q[qw % 512] = mrd_addr; qw++; reqs++;
      end
      if (hash_valid && hash_ready) begin
        chk(hash_data == memval(base + ADDR_W'(words)), "R6 word order", hash_data,
            memval(base + ADDR_W'(words)));
        chk(hash_last == (words == len - 1), "R6 last flag", hash_last, words == len - 1);
        acc = mix(acc, hash_data); qr++; words++;
        if (words == len && !done_sent) done_cd = 2;
      end
    end
    hash_done = 1'b0; mrsp_valid = 1'b0; cpu_ready = 1'b0;
    @(negedge clk);
    chk(timeout < 3000, "R7 verdict reached", timeout, 3000);
    chk(lock_ok, "R4 lock while reading", lock_ok, 1);
    chk(hold_ok, "R3 held while hashing", hold_ok, 1);
    chk(reqs == len, "R5 request count", reqs, len);
    chk(words == len, "R6 word count", words, len);
    chk(starts == (len > 0 ? 1 : 0), "R11 start count", starts, len > 0);
    repeat (5) @(negedge clk);
    if (exp_pass)
      chk(cpu_enable && !wr_lock && !boot_fail, "R7 release", {cpu_enable, wr_lock, boot_fail}, 3'b100);
    else
      chk(!cpu_enable && wr_lock && boot_fail, "R8 hold on mismatch", {cpu_enable, wr_lock, boot_fail}, 3'b011);
    chk(safe_mode == ^fuse, "R10 safe_mode frozen", safe_mode, ^fuse);
  endtask

  initial begin
    for (int f = 0; f < 256; f++) begin
      fuse_ctr = FUSE_W'(f);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(safe_mode == ^FUSE_W'(f), "R1 fuse sweep", safe_mode, ^FUSE_W'(f));
    end
    for (int n = 1; n <= 8; n++)
      for (int m = 0; m < 3; m++)
        run_case(16'h1000 + ADDR_W'(n * 16), n, -1, m, FUSE_W'(n), 1'b0, 2);
    run_case(16'hFFFE, 4, -1, 2, 8'h07, 1'b0, 1);
    run_case(16'h0200, 6, 0, 1, 8'h03, 1'b0, 1);
    run_case(16'h0300, 3, 63, 2, 8'h01, 1'b0, 1);
    run_case(16'h0400, 0, -1, 0, 8'hFF, 1'b0, 1);
    run_case(16'h0500, 7, -1, 1, 8'h0F, 1'b1, 1);
    run_case(16'h0600, 5, 31, 0, 8'h1F, 1'b1, 20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule